// File: doc/BRIEF.md
# Strobe-Framed Bus Write Capture

This block sits behind a parallel memory-style bus whose active-low chip select, output enable and write strobe arrive with no relation to the system clock. It brings all three strobes into the clock domain, throws away pulses that are too short to be real, and turns each complete, legal write cycle into exactly one single-cycle write event. The event carries the address that was present when the cycle opened and the data that was present when it closed.

A write cycle opens at the moment chip select and write strobe are both low, whichever of the two fell last. It closes at the moment either of them rises, whichever rose first. So either strobe may frame the cycle. If output enable is seen low at any point while the cycle is open, or at its close, the write is dropped.

The block also decodes a read-active control that enables the data drivers. It raises a standby flag when the strobes have been quiet for a programmable number of clocks. Any fresh strobe movement drops that flag at once, and a read that is still open keeps its drive enable while standby is shown.

Top module: `bus_strobe_capture`

## Requirements
- R1: While reset is applied and on the first clock after it is released, `wr_valid`, `rd_en` and `standby` are all 0.
- R2: `wr_addr` holds the address bus value seen when the filtered chip select and write strobe first become jointly low, whichever falls last. Later address changes inside the cycle are not reflected.
- R3: `wr_data` holds the data bus value seen when the filtered pair stops being jointly low, whichever rises first.
- R4: Each legal write cycle produces exactly one `wr_valid` pulse, one clock wide. It is raised on the clock after the filtered release is recognised, with R2/R3 values on `wr_addr`/`wr_data`.
- R5: A write cycle during which filtered output enable is low at any sampled clock, including the release clock, produces no `wr_valid`.
- R6: While chip select is high, write strobe and output enable activity produce neither `wr_valid` nor `rd_en`.
- R7: `rd_en` is 1 exactly when filtered chip select and output enable are low and filtered write strobe is high. It is 0 whenever output enable is high. `wr_valid` and `rd_en` are never 1 together.
- R8: A strobe level that lasts fewer than `GLITCH_CYC` synchronized clocks is discarded and changes no output. A level lasting `GLITCH_CYC` clocks is accepted.
- R9: `standby` rises after `IDLE_CYC` consecutive clocks in which no synchronized strobe differs from its filtered value.
- R10: A synchronized strobe that differs from its filtered value clears `standby` on the next clock. `rd_en` is not affected by `standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Raw chip select, active low |
| oe_n | input | 1 | Raw output enable, active low |
| we_n | input | 1 | Raw write strobe, active low |
| addr | input | AW | Raw address bus |
| din | input | DW | Raw data bus |
| wr_valid | output | 1 | One-clock write event |
| wr_addr | output | AW | Address of the write event |
| wr_data | output | DW | Data of the write event |
| rd_en | output | 1 | Read active; data output drive enable |
| standby | output | 1 | Bus quiet for `IDLE_CYC` clocks |

## Verification
The properties assume the host holds the address and data buses steady for a few clocks around each strobe edge. The block samples both buses through the same two-stage delay as the strobes, so a bus that changes right at an edge is not defined. The stimulus keeps every strobe level either well beyond `GLITCH_CYC` clocks or deliberately short for the glitch case. It changes the address only after capture and the data only well before or well after release. The checks compare against a history-based model of the synchronized strobes, so a run of raw levels is the only thing the model needs in order to decide when a filtered edge occurs.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int NSTB   = 3;
    localparam int STB_WE = 0;
    localparam int STB_OE = 1;
    localparam int STB_CE = 2;
    typedef logic [NSTB-1:0] strobe_t;
endpackage

// File: rtl/bsc_strobe_filter.sv
module bsc_strobe_filter #(
    parameter int GLITCH_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(GLITCH_CYC - 1)) begin
            st_d.filt = st_q.s2;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
    assign filt_o = st_q.filt;
endmodule

// File: rtl/bsc_write_capture.sv
module bsc_write_capture #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_f,
    input  logic          oe_f,
    input  logic          we_f,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en
);
    typedef struct packed {
        logic          act_prev;
        logic          bad;
        logic          wr_valid;
        logic          rd_en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cap_t;

    cap_t st_q, st_d;
    logic act;

    always_comb begin
        act             = ~ce_f & ~we_f;
        st_d            = st_q;
        st_d.wr_valid   = 1'b0;
        st_d.act_prev   = act;
        if (act && !st_q.act_prev) begin
            st_d.addr = addr_s;
            st_d.bad  = ~oe_f;
        end else if (act) begin
            st_d.bad = st_q.bad | ~oe_f;
        end
        if (!act && st_q.act_prev) begin
            st_d.data     = data_s;
            st_d.wr_valid = ~st_q.bad & oe_f;
        end
        st_d.rd_en = ~ce_f & ~oe_f & we_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.wr_valid;
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;
    assign rd_en    = st_q.rd_en;
endmodule

// File: rtl/bsc_idle_timer.sv
module bsc_idle_timer #(
    parameter int IDLE_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic standby
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sby;
    } idl_t;

    idl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (activity) begin
            st_d.cnt = '0;
            st_d.sby = 1'b0;
        end else if (st_q.cnt == CW'(IDLE_CYC - 1)) begin
            st_d.sby = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign standby = st_q.sby;
endmodule

// File: rtl/bus_strobe_capture.sv
module bus_strobe_capture
    import bsc_pkg::*;
#(
    parameter int AW         = 17,
    parameter int DW         = 8,
    parameter int GLITCH_CYC = 3,
    parameter int IDLE_CYC   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic          standby
);
    typedef struct packed {
        logic [AW-1:0] a1;
        logic [AW-1:0] a2;
        logic [DW-1:0] d1;
        logic [DW-1:0] d2;
    } pipe_t;

    strobe_t strb_raw, strb_sync, strb_filt;
    pipe_t   pp_q, pp_d;
    logic    activity;

    always_comb begin
        strb_raw         = '0;
        strb_raw[STB_CE] = ce_n;
        strb_raw[STB_OE] = oe_n;
        strb_raw[STB_WE] = we_n;
    end

    for (genvar i = 0; i < NSTB; i++) begin : g_strobe
        bsc_strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (strb_raw[i]),
            .sync_o (strb_sync[i]),
            .filt_o (strb_filt[i])
        );
    end

    always_comb begin
        pp_d    = pp_q;
        pp_d.a1 = addr;
        pp_d.a2 = pp_q.a1;
        pp_d.d1 = din;
        pp_d.d2 = pp_q.d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    assign activity = |(strb_sync ^ strb_filt);

    bsc_write_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_f     (strb_filt[STB_CE]),
        .oe_f     (strb_filt[STB_OE]),
        .we_f     (strb_filt[STB_WE]),
        .addr_s   (pp_q.a2),
        .data_s   (pp_q.d2),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en)
    );

    bsc_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (activity),
        .standby  (standby)
    );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int AW   = 17,
    parameter int NSTB = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic [AW-1:0]   wr_addr,
    input logic            rd_en,
    input logic            standby,
    input logic [NSTB-1:0] strb_sync,
    input logic [NSTB-1:0] strb_filt
);
    // R4: an event never lasts two clocks
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R2: captured address is not disturbed while the event is shown
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $stable(wr_addr));

    // R7: read drive and write event are exclusive
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_en));

    // R8: a filtered level only moves to the level the synchronizer held
    a_r8_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_filt ^ $past(strb_filt)) & (strb_filt ^ $past(strb_sync))) == '0);

    // R9: standby rises only after a quiet clock
    a_r9_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(strb_sync == strb_filt));

    // R10: fresh strobe movement drops standby on the next clock
    a_r10_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(strb_sync ^ strb_filt)) |=> !standby);
endmodule

bind bus_strobe_capture bsc_checker #(.AW(AW), .NSTB(bsc_pkg::NSTB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .rd_en     (rd_en),
    .standby   (standby),
    .strb_sync (strb_sync),
    .strb_filt (strb_filt)
);

// File: tb/tb_bus_strobe_capture.sv
module tb_bus_strobe_capture;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int G  = 3;
    localparam int IDLE = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr_valid, rd_en, standby;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int events = 0;
    logic [AW-1:0] ev_addr;
    logic [DW-1:0] ev_data;

    always #10 clk = ~clk;

    bus_strobe_capture #(.AW(AW), .DW(DW), .GLITCH_CYC(G), .IDLE_CYC(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .standby(standby)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: histories of raw samples, newest at index 0.
    logic [2:0]    rq[$];
    logic [AW-1:0] aq[$];
    logic [DW-1:0] dq[$];
    logic [2:0]    mf;
    logic          m_prev, m_bad, m_wv, m_rd, m_sby, m_ready;
    logic [AW-1:0] m_a;
    logic [DW-1:0] m_d;
    int            m_quiet;

    always @(posedge clk) begin
        if (!rst_n) begin
            rq.delete(); aq.delete(); dq.delete();
            for (int i = 0; i < G + 2; i++) begin
                rq.push_back(3'b111); aq.push_back('0); dq.push_back('0);
            end
            mf = 3'b111; m_prev = 0; m_bad = 0; m_wv = 0; m_rd = 0;
            m_sby = 0; m_a = '0; m_d = '0; m_quiet = 0; m_ready = 1;
        end else begin
            logic act;
            logic [2:0] nf;
            rq.push_front({ce_n, oe_n, we_n}); void'(rq.pop_back());
            aq.push_front(addr); void'(aq.pop_back());
            dq.push_front(din);  void'(dq.pop_back());
            if (rq[2] != mf) begin m_quiet = 0; m_sby = 0; end
            else begin
                if (m_quiet < IDLE) m_quiet++;
                if (m_quiet >= IDLE) m_sby = 1;
            end
            act  = !mf[2] && !mf[0];
            m_wv = 0;
            if (act && !m_prev) begin m_a = aq[2]; m_bad = !mf[1]; end
            else if (act) m_bad = m_bad || !mf[1];
            if (!act && m_prev) begin m_d = dq[2]; m_wv = !m_bad && mf[1]; end
            m_rd   = !mf[2] && !mf[1] && mf[0];
            m_prev = act;
            nf = mf;
            for (int b = 0; b < 3; b++) begin
                logic all_diff;
                all_diff = 1;
                for (int k = 2; k <= G + 1; k++)
                    if (rq[k][b] == mf[b]) all_diff = 0;
                if (all_diff) nf[b] = !mf[b];
            end
            mf = nf;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_ready) begin
            chk("R4 wr_valid vs model", wr_valid, m_wv);
            chk("R7 rd_en vs model", rd_en, m_rd);
            chk("R9 standby vs model", standby, m_sby);
            if (m_wv) begin
                chk("R2 wr_addr vs model", wr_addr, m_a);
                chk("R3 wr_data vs model", wr_data, m_d);
            end
            if (wr_valid) begin
                events++; ev_addr = wr_addr; ev_data = wr_data;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cyc(input bit ce_first, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input bit oe_blip);
        addr = a; din = ~d; idle(2);
        if (ce_first) ce_n = 0; else we_n = 0;
        idle(6);
        if (ce_first) we_n = 0; else ce_n = 0;
        idle(8);
        addr = ~a; din = d;
        if (oe_blip) begin oe_n = 0; idle(5); oe_n = 1; end
        idle(4);
        if (ce_first) we_n = 1; else ce_n = 1;
        idle(10);
        din = ~d;
        if (ce_first) ce_n = 1; else we_n = 1;
        idle(8);
    endtask

    initial begin
        int e0;
        idle(4);
        chk("R1 wr_valid in reset", wr_valid, 0);
        chk("R1 rd_en in reset", rd_en, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 wr_valid after reset", wr_valid, 0);
        chk("R1 rd_en after reset", rd_en, 0);
        chk("R1 standby after reset", standby, 0);

        e0 = events; write_cyc(1, 17'h1A5C3, 8'h3C, 0);
        chk("R4 one event, chip select frames", events - e0, 1);
        chk("R2 address at open", ev_addr, 17'h1A5C3);
        chk("R3 data at release", ev_data, 8'h3C);

        e0 = events; write_cyc(0, 17'h0F00F, 8'hA5, 0);
        chk("R4 one event, write strobe frames", events - e0, 1);
        chk("R2 address at open, reversed order", ev_addr, 17'h0F00F);
        chk("R3 data at release, reversed order", ev_data, 8'hA5);

        e0 = events; write_cyc(1, 17'h12345, 8'h5A, 1);
        chk("R5 output enable low cancels write", events - e0, 0);

        e0 = events; we_n = 0; oe_n = 0; idle(10);
        chk("R6 no read with chip select high", rd_en, 0);
        oe_n = 1; idle(4); we_n = 1; idle(10);
        chk("R6 no write with chip select high", events - e0, 0);

        ce_n = 0; oe_n = 0; idle(8);
        chk("R7 read active", rd_en, 1);
        oe_n = 1; idle(8);
        chk("R7 read off with output enable high", rd_en, 0);
        ce_n = 1; idle(8);

        e0 = events; ce_n = 0; idle(8);
        we_n = 0; idle(G - 1); we_n = 1; idle(10);
        ce_n = 1; idle(8);
        chk("R8 short write strobe rejected", events - e0, 0);
        e0 = events; ce_n = 0; idle(8);
        we_n = 0; idle(G); we_n = 1; idle(10);
        ce_n = 1; idle(8);
        chk("R8 strobe of full width accepted", events - e0, 1);

        idle(IDLE + 6);
        chk("R9 standby after quiet", standby, 1);
        ce_n = 0; oe_n = 0; idle(4);
        chk("R10 activity clears standby", standby, 0);
        idle(IDLE + 8);
        chk("R10 standby during open read", standby, 1);
        chk("R10 read keeps driving in standby", rd_en, 1);
        oe_n = 1; ce_n = 1; idle(8);

        e0 = events; write_cyc(0, 17'h00001, 8'hFF, 0);
        chk("R4 event after standby", events - e0, 1);
        chk("R3 data after standby", ev_data, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule